// File: doc/BRIEF.md
# USB Endpoint-0 Control Handshake Sequencer

This block holds the control and acknowledge byte for a USB device's endpoint 0. It also runs the sequencer that takes a control transfer through its setup, data and status stages. Decoded token events arrive from the serial interface engine as one-cycle pulses: SETUP received, IN token, OUT token with data, host ACK, and end of transmission. Firmware reads and writes the control byte through a simple byte-wide write port.

For each token the block answers in the following cycle. The answer is either a handshake code or a transmit enable together with the data PID to use. Four acknowledge flags record hardware events, and any flag that is set drives one interrupt line.

The block decides the status stage from two firmware bits. The direction bit selects read or write. The data-end bit marks the last packet. The ready-to-send bit is cleared only by the host's ACK, or, when the endpoint is configured as isochronous, by the end of transmission.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset the control byte reads 0x00, `irq` is 0, `rsp_code` is 0 (none) and `tx_en` is 0.
- R2: The control byte layout is: bit 7 direction (1 = control read), bit 6 data-end, bit 5 force-stall, bit 4 ready-to-send, bit 3 stall-sent flag, bit 2 setup-received flag, bit 1 OUT-received flag, bit 0 send-complete flag. A firmware write loads bits 7..4 directly, and the written value reads back in the next cycle.
- R3: Hardware sets a flag (bits 3..0) on its event. A firmware write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. A hardware set in the same cycle wins. `irq` is 1 exactly when any flag is set.
- R4: A SETUP event is answered with ACK (`rsp_code`=1). It sets the setup-received flag and clears force-stall. It abandons any IN packet still awaiting acknowledgement, so a later host ACK does nothing. The next data packet after it uses DATA1.
- R5: While force-stall is set, an IN or OUT token is answered with STALL (`rsp_code`=3) and `tx_en`=0, and the stall-sent flag is set.
- R6: An IN token with force-stall clear and ready-to-send clear is answered with NAK (`rsp_code`=2). With ready-to-send set, `tx_en`=1 and `rsp_code`=0. Data-stage packets alternate their PID (`data_pid` 1 = DATA1, 0 = DATA0), starting from DATA1, and the PID advances on each acknowledged packet.
- R7: For a non-isochronous endpoint (`iso_ep`=0), ready-to-send is cleared and the send-complete flag is set only on the host ACK that follows a transmitted packet. The end-of-transmission event leaves both unchanged.
- R8: For an isochronous endpoint (`iso_ep`=1), the end-of-transmission event after a transmitted packet clears ready-to-send and sets send-complete, with no host ACK needed.
- R9: An OUT token with force-stall clear is answered with ACK and sets the OUT-received flag when that flag is clear. It is answered with NAK when the flag is still pending.
- R10: Control read (direction=1): when the packet sent with data-end set is acknowledged, the block enters the status stage. There, IN tokens get NAK even with ready-to-send set. The next OUT is answered with ACK and sets the OUT-received flag. Data-end stays set until firmware clears it.
- R11: Control write status (direction=0, data-end=1): an IN token is answered with NAK while ready-to-send is clear. With ready-to-send set it is sent with DATA1 whatever the toggle. Its acknowledgement sets send-complete and leaves data-end set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iso_ep | input | 1 | 1 = endpoint treated as isochronous |
| ev_setup | input | 1 | SETUP packet received (pulse) |
| ev_in_tok | input | 1 | IN token received (pulse) |
| ev_out_data | input | 1 | OUT token with data received (pulse) |
| ev_host_ack | input | 1 | Host ACK received for a sent packet (pulse) |
| ev_tx_done | input | 1 | Transmission of a packet finished (pulse) |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_wdata | input | 8 | Firmware write data |
| reg_rdata | output | 8 | Current control byte |
| rsp_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| tx_en | output | 1 | Send the FIFO packet as the answer to an IN token |
| data_pid | output | 1 | PID for the sent packet: 1 DATA1, 0 DATA0 |
| irq | output | 1 | Any acknowledge flag set |

## Verification
IN tokens are swept over all sixteen settings of direction, data-end, force-stall and ready-to-send. This separates the stall, NAK and send answers. The follow-up IN after the host ACK separates the status stage of a read, the forced DATA1 of a write status, and the plain toggle of the data stage. OUT tokens are swept over force-stall against a pending OUT-received flag, which separates STALL, NAK and ACK. Directed sequences cover the rest: full control read and control write transfers, an abort by SETUP while a packet is in flight, and end of transmission with the endpoint non-isochronous and then isochronous, which checks whether ready-to-send waits for the ACK.

// File: rtl/ep0_pkg.sv
// Package: shared encodings and bit positions for the endpoint-0 sequencer.
// Assumes an 8-bit control byte with four hardware flags in the low nibble.
package ep0_pkg;
    localparam int REG_W   = 8;
    localparam int FLAG_N  = 4;
    // control bit positions (firmware decodes these)
    localparam int B_DIR   = 7;
    localparam int B_DEND  = 6;
    localparam int B_FSTL  = 5;
    localparam int B_TXRDY = 4;
    // flag indices within the low nibble
    localparam int F_STALL = 3;
    localparam int F_SETUP = 2;
    localparam int F_OUT   = 1;
    localparam int F_TXC   = 0;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DATA   = 2'd1,
        PH_STATUS = 2'd2
    } phase_e;
endpackage

// File: rtl/ep0_csr.sv
// Module: control byte storage. Firmware loads the control nibble and
// clears flags by writing 0. Hardware set/clear strobes win over a
// same-cycle firmware write. Assumes a synchronous active-low reset.
module ep0_csr
    import ep0_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NF = FLAG_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_wr_en,
    input  logic [W-1:0]  fw_wdata,
    input  logic [NF-1:0] flag_set,
    input  logic          clr_fstall,
    input  logic          clr_txrdy,
    output logic [W-1:0]  rdata
);
    localparam int CW = W - NF;

    logic [CW-1:0] ctrl_q;
    logic [NF-1:0] flag_q;

    // control nibble: firmware load, then hardware clears take precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (fw_wr_en)
                ctrl_q <= fw_wdata[W-1:NF];
            if (clr_fstall)
                ctrl_q[B_FSTL-NF] <= 1'b0;
            if (clr_txrdy)
                ctrl_q[B_TXRDY-NF] <= 1'b0;
        end
    end

    // one set-by-hardware / clear-by-firmware cell per flag
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (flag_set[i])
                flag_q[i] <= 1'b1;
            else if (fw_wr_en && !fw_wdata[i])
                flag_q[i] <= 1'b0;
        end
    end

    assign rdata = {ctrl_q, flag_q};
endmodule

// File: rtl/ep0_phase_fsm.sv
// Module: transfer stage tracker and token responder. Decides each
// token's answer one cycle after the event and issues flag/clear strobes.
// Assumes at most one token event per cycle; SETUP has top priority.
module ep0_phase_fsm
    import ep0_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NF = FLAG_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iso_ep,
    input  logic          ev_setup,
    input  logic          ev_in_tok,
    input  logic          ev_out_data,
    input  logic          ev_host_ack,
    input  logic          ev_tx_done,
    input  logic [W-1:0]  csr,
    output logic [NF-1:0] flag_set,
    output logic          clr_fstall,
    output logic          clr_txrdy,
    output hs_e           rsp_code,
    output logic          tx_en,
    output logic          data_pid
);
    phase_e ph_q, ph_d;
    logic   tog_q, tog_d;
    logic   fly_q, fly_d;
    hs_e    code_d;
    logic   txe_d, pid_d;

    logic dir, dend, fstl, txrdy, out_pend, wr_status, taken;
    assign dir       = csr[B_DIR];
    assign dend      = csr[B_DEND];
    assign fstl      = csr[B_FSTL];
    assign txrdy     = csr[B_TXRDY];
    assign out_pend  = csr[F_OUT];
    assign wr_status = !dir && dend && (ph_q != PH_STATUS);
    assign taken     = fly_q && (iso_ep ? ev_tx_done : ev_host_ack);

    // next-state, answer and strobe decision for this cycle's event
    always_comb begin
        ph_d       = ph_q;
        tog_d      = tog_q;
        fly_d      = fly_q;
        code_d     = HS_NONE;
        txe_d      = 1'b0;
        pid_d      = 1'b0;
        flag_set   = '0;
        clr_fstall = 1'b0;
        clr_txrdy  = 1'b0;
        if (ev_setup) begin
            ph_d              = PH_DATA;
            tog_d             = 1'b1;
            fly_d             = 1'b0;
            code_d            = HS_ACK;
            flag_set[F_SETUP] = 1'b1;
            clr_fstall        = 1'b1;
        end else if (ev_in_tok) begin
            if (fstl) begin
                code_d            = HS_STALL;
                flag_set[F_STALL] = 1'b1;
            end else if (ph_q == PH_STATUS || !txrdy) begin
                code_d = HS_NAK;
            end else begin
                txe_d = 1'b1;
                pid_d = wr_status ? 1'b1 : tog_q;
                fly_d = 1'b1;
            end
        end else if (ev_out_data) begin
            if (fstl) begin
                code_d            = HS_STALL;
                flag_set[F_STALL] = 1'b1;
            end else if (out_pend) begin
                code_d = HS_NAK;
            end else begin
                code_d          = HS_ACK;
                flag_set[F_OUT] = 1'b1;
                if (ph_q == PH_STATUS)
                    ph_d = PH_IDLE;
            end
        end else if (taken) begin
            fly_d           = 1'b0;
            clr_txrdy       = 1'b1;
            flag_set[F_TXC] = 1'b1;
            tog_d           = !tog_q;
            if (dend)
                ph_d = dir ? PH_STATUS : PH_IDLE;
        end
    end

    // register stage state and the one-cycle answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            tog_q    <= 1'b1;
            fly_q    <= 1'b0;
            rsp_code <= HS_NONE;
            tx_en    <= 1'b0;
            data_pid <= 1'b0;
        end else begin
            ph_q     <= ph_d;
            tog_q    <= tog_d;
            fly_q    <= fly_d;
            rsp_code <= code_d;
            tx_en    <= txe_d;
            data_pid <= pid_d;
        end
    end
endmodule

// File: rtl/ep0_ctrl_seq.sv
// Module: top of the endpoint-0 control handshake sequencer. Joins the
// control byte storage with the stage tracker and forms the interrupt.
// Assumes one-cycle event pulses and a synchronous active-low reset.
module ep0_ctrl_seq
    import ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iso_ep,
    input  logic       ev_setup,
    input  logic       ev_in_tok,
    input  logic       ev_out_data,
    input  logic       ev_host_ack,
    input  logic       ev_tx_done,
    input  logic       fw_wr_en,
    input  logic [7:0] fw_wdata,
    output logic [7:0] reg_rdata,
    output logic [1:0] rsp_code,
    output logic       tx_en,
    output logic       data_pid,
    output logic       irq
);
    logic [FLAG_N-1:0] flag_set;
    logic              clr_fstall, clr_txrdy;
    hs_e               code;

    ep0_csr #(.W(REG_W), .NF(FLAG_N)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fw_wr_en   (fw_wr_en),
        .fw_wdata   (fw_wdata),
        .flag_set   (flag_set),
        .clr_fstall (clr_fstall),
        .clr_txrdy  (clr_txrdy),
        .rdata      (reg_rdata)
    );

    ep0_phase_fsm #(.W(REG_W), .NF(FLAG_N)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .iso_ep      (iso_ep),
        .ev_setup    (ev_setup),
        .ev_in_tok   (ev_in_tok),
        .ev_out_data (ev_out_data),
        .ev_host_ack (ev_host_ack),
        .ev_tx_done  (ev_tx_done),
        .csr         (reg_rdata),
        .flag_set    (flag_set),
        .clr_fstall  (clr_fstall),
        .clr_txrdy   (clr_txrdy),
        .rsp_code    (code),
        .tx_en       (tx_en),
        .data_pid    (data_pid)
    );

    // interrupt: any hardware flag pending
    assign irq      = |reg_rdata[FLAG_N-1:0];
    assign rsp_code = code;
endmodule

// File: rtl/ep0_ctrl_seq_chk.sv
// Module: protocol checker bound to the sequencer top; observes ports only.
module ep0_ctrl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iso_ep,
    input logic       ev_setup,
    input logic       ev_in_tok,
    input logic       ev_out_data,
    input logic       ev_host_ack,
    input logic       ev_tx_done,
    input logic       fw_wr_en,
    input logic [7:0] reg_rdata,
    input logic [1:0] rsp_code,
    input logic       tx_en
);
    assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (rsp_code == 2'd1) && reg_rdata[2] && !reg_rdata[5]);

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in_tok && !ev_setup && reg_rdata[5])
        |=> (rsp_code == 2'd3) && !tx_en && reg_rdata[3]);

    assert_send_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> $past(reg_rdata[4]));

    assert_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[4] && !fw_wr_en && !ev_host_ack && !(iso_ep && ev_tx_done))
        |=> reg_rdata[4]);

    assert_out_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_out_data && !ev_setup && !ev_in_tok && !reg_rdata[5] && reg_rdata[1])
        |=> (rsp_code == 2'd2));

    assert_dend_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] && !fw_wr_en) |=> reg_rdata[6]);
endmodule

bind ep0_ctrl_seq ep0_ctrl_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iso_ep      (iso_ep),
    .ev_setup    (ev_setup),
    .ev_in_tok   (ev_in_tok),
    .ev_out_data (ev_out_data),
    .ev_host_ack (ev_host_ack),
    .ev_tx_done  (ev_tx_done),
    .fw_wr_en    (fw_wr_en),
    .reg_rdata   (reg_rdata),
    .rsp_code    (rsp_code),
    .tx_en       (tx_en)
);

// File: tb/ep0_ctrl_seq_tb.sv
module ep0_ctrl_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iso_ep = 1'b0;
    logic       ev_setup = 1'b0, ev_in_tok = 1'b0, ev_out_data = 1'b0;
    logic       ev_host_ack = 1'b0, ev_tx_done = 1'b0;
    logic       fw_wr_en = 1'b0;
    logic [7:0] fw_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] rsp_code;
    logic       tx_en, data_pid, irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;  // 125 MHz

    ep0_ctrl_seq u_dut (
        .clk(clk), .rst_n(rst_n), .iso_ep(iso_ep),
        .ev_setup(ev_setup), .ev_in_tok(ev_in_tok), .ev_out_data(ev_out_data),
        .ev_host_ack(ev_host_ack), .ev_tx_done(ev_tx_done),
        .fw_wr_en(fw_wr_en), .fw_wdata(fw_wdata), .reg_rdata(reg_rdata),
        .rsp_code(rsp_code), .tx_en(tx_en), .data_pid(data_pid), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pulse one event for one cycle; return at the negedge after the edge
    // 0 setup, 1 in, 2 out, 3 host ack, 4 tx done
    task automatic tok(input int k);
        @(negedge clk);
        ev_setup    = (k == 0);
        ev_in_tok   = (k == 1);
        ev_out_data = (k == 2);
        ev_host_ack = (k == 3);
        ev_tx_done  = (k == 4);
        @(negedge clk);
        ev_setup = 0; ev_in_tok = 0; ev_out_data = 0;
        ev_host_ack = 0; ev_tx_done = 0;
    endtask

    task automatic fw(input logic [7:0] d);
        @(negedge clk);
        fw_wr_en = 1'b1; fw_wdata = d;
        @(negedge clk);
        fw_wr_en = 1'b0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 rsp", rsp_code, 0);
        chk("R1 txen", tx_en, 0);

        // R2 readback of control nibble
        fw(8'hF0);
        chk("R2 readback", reg_rdata, 8'hF0);
        fw(8'h00);

        // R3 flag set/clear and irq
        tok(0);
        chk("R3 setup flag", reg_rdata[2], 1);
        chk("R3 irq on", irq, 1);
        fw(8'h0F);
        chk("R3 write1 no effect", reg_rdata[2], 1);
        fw(8'h0B);
        chk("R3 write0 clears", reg_rdata[2], 0);
        chk("R3 irq off", irq, 0);

        // R4 setup clears force-stall and answers ACK
        fw(8'h20);
        tok(0);
        chk("R4 ack", rsp_code, 1);
        chk("R4 fstall cleared", reg_rdata[5], 0);
        // R4 abort of an in-flight packet
        fw(8'h10);
        tok(1);
        chk("R4 sent", tx_en, 1);
        tok(0);
        tok(3);
        chk("R4 abort ready kept", reg_rdata[4], 1);
        chk("R4 abort no txc", reg_rdata[0], 0);

        // R6/R5 sweep IN over {dir,dend,fstall,ready}
        for (int s = 0; s < 16; s++) begin
            logic dr, de, fs, tp;
            dr = s[3]; de = s[2]; fs = s[1]; tp = s[0];
            tok(0);
            fw({dr, de, fs, tp, 4'b0000});
            tok(1);
            chk("R5/R6 in code", rsp_code, fs ? 3 : (tp ? 0 : 2));
            chk("R6 in txen", tx_en, (!fs && tp) ? 1 : 0);
            if (!fs && tp) chk("R6 first pid", data_pid, 1);
            chk("R5 stall flag", reg_rdata[3], fs ? 1 : 0);
            if (!fs && tp) begin
                tok(3);
                chk("R7 ack clears ready", reg_rdata[4], 0);
                chk("R7 ack sets txc", reg_rdata[0], 1);
                chk("R10 dend kept", reg_rdata[6], de ? 1 : 0);
                fw({dr, de, 2'b01, 4'b1111});
                tok(1);
                if (dr && de) begin
                    chk("R10 status nak", rsp_code, 2);
                end else begin
                    chk("R6 second txen", tx_en, 1);
                    chk("R6/R11 second pid", data_pid, (!dr && de) ? 1 : 0);
                end
            end
        end

        // R9/R5 sweep OUT over {fstall, pending}
        for (int s = 0; s < 4; s++) begin
            logic fs, pd;
            fs = s[1]; pd = s[0];
            tok(0);
            fw(8'h00);
            if (pd) tok(2);
            fw({2'b00, fs, 1'b0, 4'b1111});
            tok(2);
            chk("R5/R9 out code", rsp_code, fs ? 3 : (pd ? 2 : 1));
            chk("R9 out flag", reg_rdata[1], (fs && !pd) ? 0 : 1);
            chk("R5 out stall flag", reg_rdata[3], fs ? 1 : 0);
        end

        // R7 non-iso: tx done does not clear
        iso_ep = 1'b0;
        tok(0);
        fw(8'h10);
        tok(1);
        tok(4);
        chk("R7 txdone keeps ready", reg_rdata[4], 1);
        chk("R7 txdone no txc", reg_rdata[0], 0);
        tok(3);
        chk("R7 ack clears", reg_rdata[4], 0);

        // R8 iso: tx done clears
        iso_ep = 1'b1;
        tok(0);
        fw(8'h10);
        tok(1);
        tok(4);
        chk("R8 iso ready cleared", reg_rdata[4], 0);
        chk("R8 iso txc", reg_rdata[0], 1);
        iso_ep = 1'b0;

        // R10 full control read
        tok(0);
        fw(8'h90);
        tok(1);
        chk("R10 pid1", data_pid, 1);
        tok(3);
        fw(8'hD0);
        tok(1);
        chk("R10 pid0", data_pid, 0);
        tok(3);
        fw(8'hD0);
        tok(1);
        chk("R10 status in nak", rsp_code, 2);
        tok(2);
        chk("R10 status out ack", rsp_code, 1);
        chk("R10 out flag", reg_rdata[1], 1);
        chk("R10 dend stays", reg_rdata[6], 1);

        // R11 full control write
        tok(0);
        fw(8'h00);
        tok(2);
        chk("R11 data out ack", rsp_code, 1);
        fw(8'h40);
        tok(1);
        chk("R11 nak w/o ready", rsp_code, 2);
        fw(8'h50);
        tok(1);
        chk("R11 status txen", tx_en, 1);
        chk("R11 status DATA1", data_pid, 1);
        tok(3);
        chk("R11 txc", reg_rdata[0], 1);
        chk("R11 dend stays", reg_rdata[6], 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule